// File: doc/BRIEF.md
# Subroutine Return Target Predictor

This block guesses where a subroutine return will land, early in the pipeline, before the return has been executed. Each cycle it may receive one 32-bit instruction word in SPARC format, with a valid flag and the address of that instruction. A call pushes the address that follows its delay slot (its own address plus 8) onto a small circular stack. A recognised return idiom pops the newest entry, and that entry is presented in the same cycle as the predicted target.

The stack has a fixed number of slots. When it is full, a push overwrites the oldest entry. An occupancy counter tracks how many entries can still be trusted. If a pop finds the stack empty, the block still returns whatever is under the pointer but flags the prediction as unreliable. The execute stage reports the real target of each resolved return, together with a flag that says whether the guess was wrong. On a wrong guess the block sends a one-cycle redirect, one clock later, carrying the correct address.

Top module: `ret_stack_predictor`

## Requirements
- R1: A valid instruction with bits[31:30]=01 (call) pushes its address plus 8.
- R2: A valid jump-and-link (bits[31:30]=10, bits[24:19]=0x38) with destination field bits[29:25]=15 pushes its address plus 8. A jump-and-link with any other destination does not push.
- R3: A valid jump-and-link with immediate bit 13 set, bits[12:0]=8 and base field bits[18:14]=15 is a return. In the same cycle it raises predHit with predTarget equal to the newest entry, and it pops that entry.
- R4: The same form with base field 31 is also a return and behaves exactly as in R3.
- R5: A jump-and-link that differs from the return form in its base register, its offset or its immediate bit raises no predHit and pops nothing.
- R6: When instValid is low the instruction word has no effect: no prediction, no push, no pop.
- R7: The stack holds DEPTH entries (8 by default). A push into a full stack overwrites the oldest entry. Later pops return the newest DEPTH addresses newest first, then continue around the ring into stale slots.
- R8: A return seen while occupancy is zero still gives predHit and the slot under the pointer, and still moves the pointer, but holds predReliable low. predReliable is high for a return whenever occupancy is nonzero.
- R9: An instruction that is both a return and a push predicts the old top, pops it, and then pushes its own address plus 8 in the same cycle. That new value is the next top.
- R10: resolveValid together with resolveMismatch produces redirectValid high for exactly the next cycle, with redirectTarget equal to resolveTarget from that cycle. A resolution without a mismatch produces no redirect.
- R11: A synchronous active-high reset empties the stack, so the first return after reset has predReliable low, and it clears redirectValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | Instruction word is present this cycle |
| instWord | input | 32 | Instruction word to decode |
| instPc | input | 32 | Address of the instruction |
| predHit | output | 1 | A return was recognised this cycle |
| predTarget | output | 32 | Predicted return target (top entry) |
| predReliable | output | 1 | Prediction came from a live entry |
| resolveValid | input | 1 | Execute stage resolved a return |
| resolveMismatch | input | 1 | The resolved target differed from the prediction |
| resolveTarget | input | 32 | Correct target of the resolved return |
| redirectValid | output | 1 | One-cycle fetch redirect pulse |
| redirectTarget | output | 32 | Address to restart fetch from |

## Verification
The bench goes after overflow. Nesting runs past the depth and then unwinds past empty. A design that refuses the push or saturates the pointer would give the wrong entry, and one that lets occupancy wrap would report stale guesses as reliable. It also tries near-miss encodings (offset 12, register form, base register 14) and a valid flag held low, where a loose decoder would pop spuriously. It sends a return that also writes the link register, which catches a design that pushes before it pops and so predicts its own address. It also checks that a redirect lasts one cycle and carries the target of the right cycle, not a neighbouring one.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  typedef struct packed {
    logic push;
    logic pop;
    logic redirect;
  } rspStrobes_t;

  localparam logic [5:0] OP3_JMPL = 6'h38;
  localparam logic [4:0] REG_O7 = 5'd15;
  localparam logic [4:0] REG_I7 = 5'd31;
  localparam logic [12:0] RET_OFFSET = 13'd8;

  function automatic logic isCall(input logic [31:0] w);
    return w[31:30] == 2'b01;
  endfunction

  function automatic logic isJmpl(input logic [31:0] w);
    return (w[31:30] == 2'b10) && (w[24:19] == OP3_JMPL);
  endfunction

  function automatic logic linksO7(input logic [31:0] w);
    return isCall(w) || (isJmpl(w) && (w[29:25] == REG_O7));
  endfunction

  function automatic logic isReturn(input logic [31:0] w);
    return isJmpl(w) && w[13] && (w[12:0] == RET_OFFSET) &&
           ((w[18:14] == REG_O7) || (w[18:14] == REG_I7));
  endfunction

endpackage

// File: rtl/rsp_ctrl.sv
module rsp_ctrl
  import rsp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic              resolveValid,
  input  logic              resolveMismatch,
  output rspStrobes_t       strobes,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              stackLive
);

  logic [IDX_W-1:0] topPtr, ptrAfterPop, ptrNext;
  logic [CNT_W-1:0] occCnt, cntAfterPop, cntNext;
  logic pushReq, popReq;

  function automatic logic [IDX_W-1:0] incIdx(input logic [IDX_W-1:0] v);
    return (v == IDX_W'(DEPTH - 1)) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] decIdx(input logic [IDX_W-1:0] v);
    return (v == '0) ? IDX_W'(DEPTH - 1) : v - 1'b1;
  endfunction

  // decode: pop is ordered ahead of push within one instruction
  always_comb begin
    pushReq = instValid && linksO7(instWord);
    popReq  = instValid && isReturn(instWord);
  end

  always_comb begin
    ptrAfterPop = popReq ? decIdx(topPtr) : topPtr;
    ptrNext     = pushReq ? incIdx(ptrAfterPop) : ptrAfterPop;
    cntAfterPop = (popReq && occCnt != '0) ? occCnt - 1'b1 : occCnt;
    cntNext     = (pushReq && cntAfterPop != CNT_W'(DEPTH)) ? cntAfterPop + 1'b1
                                                            : cntAfterPop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      topPtr <= '0;
      occCnt <= '0;
    end else begin
      topPtr <= ptrNext;
      occCnt <= cntNext;
    end
  end

  always_comb begin
    strobes.push     = pushReq;
    strobes.pop      = popReq;
    strobes.redirect = resolveValid && resolveMismatch;
    rdIdx            = topPtr;
    wrIdx            = incIdx(ptrAfterPop);
    stackLive        = occCnt != '0;
  end

  // R7: occupancy saturates at the depth
  a_r7_occ_bounded: assert property (@(posedge clk) disable iff (rst)
    occCnt <= CNT_W'(DEPTH));

  // R7: a lone push into a full stack keeps it full and moves the pointer on
  a_r7_full_push_wraps: assert property (@(posedge clk) disable iff (rst)
    (pushReq && !popReq && occCnt == CNT_W'(DEPTH)) |=>
      (occCnt == CNT_W'(DEPTH)) && (topPtr == incIdx($past(topPtr))));

  // R8: a pop from empty leaves occupancy at zero but still moves the pointer
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (popReq && !pushReq && occCnt == '0) |=>
      (occCnt == '0) && (topPtr == decIdx($past(topPtr))));

  // R9: pop plus push leaves the pointer in place
  a_r9_pop_then_push: assert property (@(posedge clk) disable iff (rst)
    (popReq && pushReq) |=> $stable(topPtr) && occCnt != '0);

  // R6: nothing moves without a valid instruction
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !instValid |=> $stable(topPtr) && $stable(occCnt));

endmodule

// File: rtl/rsp_datapath.sv
module rsp_datapath
  import rsp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  rspStrobes_t       strobes,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              stackLive,
  input  logic [31:0]       instPc,
  input  logic [31:0]       resolveTarget,
  output logic              predHit,
  output logic [31:0]       predTarget,
  output logic              predReliable,
  output logic              redirectValid,
  output logic [31:0]       redirectTarget
);

  logic [31:0] slots [DEPTH];
  logic [31:0] linkAddr;

  assign linkAddr = instPc + 32'd8;

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strobes.push && wrIdx == IDX_W'(g))
        slots[g] <= linkAddr;
    end
  end

  // read sees the pre-write contents, so a pop-then-push predicts the old top
  always_comb begin
    predHit      = strobes.pop;
    predTarget   = slots[rdIdx];
    predReliable = strobes.pop && stackLive;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirectValid  <= 1'b0;
      redirectTarget <= '0;
    end else begin
      redirectValid <= strobes.redirect;
      if (strobes.redirect)
        redirectTarget <= resolveTarget;
    end
  end

  // R10: a redirect only follows a mismatched resolution one cycle earlier
  a_r10_redirect_cause: assert property (@(posedge clk) disable iff (rst)
    redirectValid |-> $past(strobes.redirect));

  // R10: the redirect carries the target that came with the mismatch
  a_r10_redirect_target: assert property (@(posedge clk) disable iff (rst)
    strobes.redirect |=> redirectValid && redirectTarget == $past(resolveTarget));

  // R8: reliability is only claimed alongside a prediction
  a_r8_reliable_needs_hit: assert property (@(posedge clk) disable iff (rst)
    predReliable |-> predHit);

endmodule

// File: rtl/ret_stack_predictor.sv
module ret_stack_predictor
  import rsp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        instValid,
  input  logic [31:0] instWord,
  input  logic [31:0] instPc,
  output logic        predHit,
  output logic [31:0] predTarget,
  output logic        predReliable,
  input  logic        resolveValid,
  input  logic        resolveMismatch,
  input  logic [31:0] resolveTarget,
  output logic        redirectValid,
  output logic [31:0] redirectTarget
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rspStrobes_t      strobes;
  logic [IDX_W-1:0] rdIdx, wrIdx;
  logic             stackLive;

  rsp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .instValid       (instValid),
    .instWord        (instWord),
    .resolveValid    (resolveValid),
    .resolveMismatch (resolveMismatch),
    .strobes         (strobes),
    .rdIdx           (rdIdx),
    .wrIdx           (wrIdx),
    .stackLive       (stackLive)
  );

  rsp_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk            (clk),
    .rst            (rst),
    .strobes        (strobes),
    .rdIdx          (rdIdx),
    .wrIdx          (wrIdx),
    .stackLive      (stackLive),
    .instPc         (instPc),
    .resolveTarget  (resolveTarget),
    .predHit        (predHit),
    .predTarget     (predTarget),
    .predReliable   (predReliable),
    .redirectValid  (redirectValid),
    .redirectTarget (redirectTarget)
  );

endmodule

// File: tb/ret_stack_predictor_tb.sv
module ret_stack_predictor_tb;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        instValid;
  logic [31:0] instWord, instPc;
  logic        predHit, predReliable;
  logic [31:0] predTarget;
  logic        resolveValid, resolveMismatch;
  logic [31:0] resolveTarget;
  logic        redirectValid;
  logic [31:0] redirectTarget;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] mMem [DEPTH];
  bit          mKnown [DEPTH];
  int          mPtr, mCnt;
  bit          prevRedir;
  logic [31:0] prevTgt;

  always #5 clk = ~clk;

  ret_stack_predictor #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .instPc(instPc), .predHit(predHit), .predTarget(predTarget),
    .predReliable(predReliable), .resolveValid(resolveValid),
    .resolveMismatch(resolveMismatch), .resolveTarget(resolveTarget),
    .redirectValid(redirectValid), .redirectTarget(redirectTarget)
  );

  function automatic logic [31:0] mkCall(input logic [29:0] disp);
    return {2'b01, disp};
  endfunction

  function automatic logic [31:0] mkJmpl(input logic [4:0] rd, input logic [4:0] rs1,
                                         input logic i, input logic [12:0] low);
    return {2'b10, rd, 6'h38, rs1, i, low};
  endfunction

  function automatic bit expReturn(input logic [31:0] w);
    return w[31:30] == 2'b10 && w[24:19] == 6'h38 && w[13] && w[12:0] == 13'd8 &&
           (w[18:14] == 5'd15 || w[18:14] == 5'd31);
  endfunction

  function automatic bit expPush(input logic [31:0] w);
    return w[31:30] == 2'b01 || (w[31:30] == 2'b10 && w[24:19] == 6'h38 && w[29:25] == 5'd15);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; instValid = 0; instWord = 0; instPc = 0;
    resolveValid = 0; resolveMismatch = 0; resolveTarget = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mPtr = 0; mCnt = 0; prevRedir = 0; prevTgt = 0;
  endtask

  task automatic step(input bit v, input logic [31:0] w, input logic [31:0] pc,
                      input bit rv, input bit rm, input logic [31:0] rt,
                      input string req);
    bit hit;
    @(negedge clk);
    instValid = v; instWord = w; instPc = pc;
    resolveValid = rv; resolveMismatch = rm; resolveTarget = rt;
    #2;
    hit = v && expReturn(w);
    check(predHit == hit, req, 32'(predHit), 32'(hit));
    if (hit) begin
      check(predReliable == (mCnt > 0), {req, " R8"}, 32'(predReliable), 32'(mCnt > 0));
      if (mKnown[mPtr])
        check(predTarget == mMem[mPtr], req, predTarget, mMem[mPtr]);
    end
    check(redirectValid == prevRedir, "R10 valid", 32'(redirectValid), 32'(prevRedir));
    if (prevRedir)
      check(redirectTarget == prevTgt, "R10 target", redirectTarget, prevTgt);
    if (hit) begin
      if (mCnt > 0) mCnt--;
      mPtr = (mPtr + DEPTH - 1) % DEPTH;
    end
    if (v && expPush(w)) begin
      mPtr = (mPtr + 1) % DEPTH;
      mMem[mPtr] = pc + 32'd8;
      mKnown[mPtr] = 1;
      if (mCnt < DEPTH) mCnt++;
    end
    prevRedir = rv && rm;
    prevTgt = rt;
  endtask

  localparam logic [31:0] RETL = 32'h81C3E008;
  localparam logic [31:0] RET  = 32'h81C7E008;

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240601));
    for (int k = 0; k < DEPTH; k++) mKnown[k] = 0;
    check(RETL == mkJmpl(5'd0, 5'd15, 1'b1, 13'd8), "R3 encoding", RETL, mkJmpl(0, 15, 1, 8));
    doReset();
    #2;
    // R11: reset state
    check(predHit == 0, "R11 idle", 32'(predHit), 0);
    check(redirectValid == 0, "R11 redirect", 32'(redirectValid), 0);
    step(1, mkCall(30'h10), 32'h0000_1000, 0, 0, 0, "R1");
    doReset();
    step(1, RETL, 32'h0000_1100, 0, 0, 0, "R11");
    // R1/R3 call then retl
    step(1, mkCall(30'h40), 32'h0000_1000, 0, 0, 0, "R1");
    step(1, RETL, 32'h0000_1104, 0, 0, 0, "R3");
    // R2/R4 jmpl to %o7 then ret
    step(1, mkJmpl(5'd15, 5'd3, 1'b0, 13'd4), 32'h0000_2000, 0, 0, 0, "R2");
    step(1, mkJmpl(5'd5, 5'd3, 1'b0, 13'd4), 32'h0000_2100, 0, 0, 0, "R2");
    step(1, RET, 32'h0000_2200, 0, 0, 0, "R4");
    // R5 near misses
    step(1, mkCall(30'h7), 32'h0000_3000, 0, 0, 0, "R1");
    step(1, mkJmpl(5'd0, 5'd15, 1'b1, 13'd12), 32'h0000_3004, 0, 0, 0, "R5");
    step(1, mkJmpl(5'd0, 5'd15, 1'b0, 13'd8), 32'h0000_3008, 0, 0, 0, "R5");
    step(1, mkJmpl(5'd0, 5'd14, 1'b1, 13'd8), 32'h0000_300C, 0, 0, 0, "R5");
    // R6 invalid instructions
    step(0, RETL, 32'h0000_3010, 0, 0, 0, "R6");
    step(0, mkCall(30'h1), 32'h0000_3014, 0, 0, 0, "R6");
    step(1, RETL, 32'h0000_3018, 0, 0, 0, "R6");
    // R9 return that also links
    step(1, mkCall(30'h2), 32'h0000_4000, 0, 0, 0, "R1");
    step(1, mkJmpl(5'd15, 5'd15, 1'b1, 13'd8), 32'h0000_4100, 0, 0, 0, "R9");
    step(1, RETL, 32'h0000_4200, 0, 0, 0, "R9");
    // R7 overflow then unwind past empty (R8)
    doReset();
    for (int k = 0; k < DEPTH + 3; k++)
      step(1, mkCall(30'(k)), 32'h0001_0000 + 32'(k * 16), 0, 0, 0, "R7");
    for (int k = 0; k < DEPTH + 4; k++)
      step(1, (k % 2) ? RET : RETL, 32'h0002_0000 + 32'(k * 4), 0, 0, 0, "R7");
    // R10 redirect pulses
    step(1, 32'h0100_0000, 32'h5000, 1, 1, 32'hCAFE_0010, "R10");
    step(1, 32'h0100_0000, 32'h5004, 0, 0, 0, "R10");
    step(1, 32'h0100_0000, 32'h5008, 1, 0, 32'h1234_5678, "R10");
    step(1, 32'h0100_0000, 32'h500C, 1, 1, 32'hBEEF_0020, "R10");
    step(1, 32'h0100_0000, 32'h5010, 1, 1, 32'hBEEF_0030, "R10");
    step(1, 32'h0100_0000, 32'h5014, 0, 0, 0, "R10");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic [31:0] w;
      sel = int'($urandom % 12);
      case (sel)
        0, 1, 2: w = mkCall(30'($urandom));
        3:       w = mkJmpl(5'd15, 5'($urandom), 1'($urandom), 13'($urandom));
        4, 5, 6: w = RETL;
        7:       w = RET;
        8:       w = mkJmpl(5'd15, 5'd31, 1'b1, 13'd8);
        9:       w = mkJmpl(5'($urandom), 5'd15, 1'b1, 13'($urandom % 16));
        default: w = $urandom;
      endcase
      step(($urandom % 8) != 0, w, {$urandom} & 32'hFFFF_FFFC,
           ($urandom % 4) == 0, ($urandom % 2) == 0, $urandom, "R7 random");
    end
    step(0, 0, 0, 0, 0, 0, "R10");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule